// File: doc/BRIEF.md
# Multicycle Accumulator CPU Core

This block is a small 8-bit processor that steps through each instruction one T-state (one clock cycle) at a time. It holds an accumulator A, two general registers B and C, a 16-bit program counter, a hidden operand latch that feeds the ALU, and two condition flags: zero and sign. Instructions are one, two or three bytes long and use a fixed subset of a classic 8-bit opcode map. Both instructions and data pass through one single-port synchronous memory port.

The core reads and writes memory through a 16-bit address, an 8-bit write data bus with a write strobe, and an 8-bit read data bus. Read data returns one clock after the address is presented. A write takes effect on the clock edge where the strobe is high. A one-level subroutine call is supported: the return address is kept in the two top bytes of memory, so a second call made before a return overwrites the first. After a halt instruction the core freezes and raises `halted` until reset.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst` is high at a rising edge, PC, A, B, C, the operand latch, both flags and the T-state counter are cleared. During reset, `mem_addr` is 0, `mem_we` is 0 and `halted` is 0.
- R2: Each instruction begins with a three-cycle fetch. Cycle 1 presents the PC, cycle 2 captures the opcode from `mem_rdata` and advances the PC, and cycle 3 starts execution. There are no writes in those cycles. A 16-bit operand is stored low byte first.
- R3: The two-operand ALU opcodes write their result to A. ADD B/C = 80/81, SUB B/C = 90/91, ANA B/C = A0/A1, ORA B/C = B0/B1, XRA B/C = A8/A9. The immediate forms ANI = E6, ORI = F6 and XRI = EE apply AND, OR and XOR with the following byte.
- R4: CMA (2F) inverts A. RAL (17) rotates A left, with bit 7 moving into bit 0. RAR (1F) shifts A right, with 0 entering bit 7.
- R5: MOV copies one register to another: 78 A<-B, 79 A<-C, 47 B<-A, 41 B<-C, 4F C<-A, 48 C<-B. MVI A/B/C = 3E/06/0E load the following byte. INR A/B/C = 3C/04/0C and DCR A/B/C = 3D/05/0D increment or decrement their register modulo 256.
- R6: Z means the value is zero and S is bit 7 of the value. The ALU opcodes of R3 set both flags from the new A. INR and DCR set both flags from the register they changed. Every other instruction leaves the flags unchanged.
- R7: JMP (C3) always jumps. JZ (CA) jumps when Z=1, JNZ (C2) jumps when Z=0, and JM (FA) jumps when S=1. The condition is decided in T-state 4. A jump that is not taken ends there, and the PC moves past both address bytes.
- R8: Instruction lengths in T-states: NOP 3; MOV, INR, DCR, CMA, RAL, RAR and HLT 4; register ALU 5; MVI 6; immediate ALU 7; JMP and taken conditional jumps 8; not-taken conditional jumps 4; CALL and STA 9; LDA 10; RET 5.
- R9: CALL (CD) writes the address that follows the CALL instruction, high byte to FFFE and then low byte to FFFF, and jumps to its operand. RET (C9) loads the PC from FFFE (high) and FFFF (low).
- R10: LDA (3A) loads A from the addressed byte. STA (32) writes A to the addressed byte. These are the only memory writes apart from the two made by CALL.
- R11: HLT (76) sets `halted`. From then until reset, the core makes no writes and `mem_addr` is constant. Any opcode not listed behaves as a 4-state NOP.
- R12: The program that multiplies by repeated addition (A=0, B=12, C=8, then a loop of ADD B, DCR C, JZ out, JMP back) leaves A = 96 and halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory address for the current T-state |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write strobe, applied on the same rising edge |
| mem_rdata | input | 8 | Byte read from the address presented one cycle earlier |
| halted | output | 1 | High after a halt instruction, until reset |

## Verification
The properties take the memory contract for granted. `mem_rdata` must return the byte at the address of the previous cycle with exactly one cycle of latency, and reset must be held across at least one rising edge before being released. The bench memory model is registered in exactly that way, and it holds reset for three edges before every program. The memory model only decodes the low address bits, so the programs stay in a low window and the two return-address bytes are reached through that aliasing. Results are made visible only through STA and CALL writes, which a scoreboard compares in order.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int TW = 4;

    typedef enum logic [3:0] {
        K_NOP, K_MOV, K_INR, K_DCR, K_UNA, K_ALUR, K_MVI, K_ALUI,
        K_JMP, K_JCC, K_CALL, K_RET, K_LDA, K_STA, K_HLT
    } kind_e;

    typedef enum logic [2:0] {
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOT, OP_ROL, OP_SHR
    } aluop_e;

    typedef enum logic [1:0] {CC_NONE, CC_Z, CC_NZ, CC_M} cond_e;

    localparam logic [1:0] R_A = 2'd0;
    localparam logic [1:0] R_B = 2'd1;
    localparam logic [1:0] R_C = 2'd2;

    localparam logic [7:0] OPC_JZ  = 8'hCA;
    localparam logic [7:0] OPC_JNZ = 8'hC2;
    localparam logic [7:0] OPC_JM  = 8'hFA;

    typedef struct packed {
        kind_e           kind;
        logic [1:0]      dst;
        logic [1:0]      src;
        aluop_e          op;
        cond_e           cc;
        logic [TW-1:0]   last_t;
    } dec_t;

    // three-bit register field of the opcode map: 0=B, 1=C, 7=A
    function automatic logic [1:0] reg_of(input logic [2:0] f);
        case (f)
            3'd0:    return R_B;
            3'd1:    return R_C;
            default: return R_A;
        endcase
    endfunction

    function automatic logic [TW-1:0] kind_len(input kind_e k);
        case (k)
            K_NOP:           return 4'd3;
            K_ALUR, K_RET:   return 4'd5;
            K_MVI:           return 4'd6;
            K_ALUI:          return 4'd7;
            K_JMP, K_JCC:    return 4'd8;
            K_CALL, K_STA:   return 4'd9;
            K_LDA:           return 4'd10;
            default:         return 4'd4;
        endcase
    endfunction

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
    import acc_cpu_pkg::*;
(
    input  logic [7:0] opc,
    output dec_t       dec
);
    logic undef;

    always_comb begin
        dec       = '0;
        dec.kind  = K_NOP;
        dec.op    = OP_ADD;
        dec.cc    = CC_NONE;
        dec.dst   = reg_of(opc[5:3]);
        dec.src   = reg_of(opc[2:0]);
        undef     = 1'b0;
        case (opc)
            8'h00: dec.kind = K_NOP;
            8'h76: dec.kind = K_HLT;
            8'h78, 8'h79, 8'h47, 8'h41, 8'h4F, 8'h48: dec.kind = K_MOV;
            8'h3C, 8'h04, 8'h0C: dec.kind = K_INR;
            8'h3D, 8'h05, 8'h0D: dec.kind = K_DCR;
            8'h3E, 8'h06, 8'h0E: dec.kind = K_MVI;
            8'h80, 8'h81: begin dec.kind = K_ALUR; dec.op = OP_ADD; end
            8'h90, 8'h91: begin dec.kind = K_ALUR; dec.op = OP_SUB; end
            8'hA0, 8'hA1: begin dec.kind = K_ALUR; dec.op = OP_AND; end
            8'hB0, 8'hB1: begin dec.kind = K_ALUR; dec.op = OP_OR;  end
            8'hA8, 8'hA9: begin dec.kind = K_ALUR; dec.op = OP_XOR; end
            8'hE6: begin dec.kind = K_ALUI; dec.op = OP_AND; end
            8'hF6: begin dec.kind = K_ALUI; dec.op = OP_OR;  end
            8'hEE: begin dec.kind = K_ALUI; dec.op = OP_XOR; end
            8'h2F: begin dec.kind = K_UNA;  dec.op = OP_NOT; end
            8'h17: begin dec.kind = K_UNA;  dec.op = OP_ROL; end
            8'h1F: begin dec.kind = K_UNA;  dec.op = OP_SHR; end
            8'hC3: dec.kind = K_JMP;
            OPC_JZ:  begin dec.kind = K_JCC; dec.cc = CC_Z;  end
            OPC_JNZ: begin dec.kind = K_JCC; dec.cc = CC_NZ; end
            OPC_JM:  begin dec.kind = K_JCC; dec.cc = CC_M;  end
            8'hCD: dec.kind = K_CALL;
            8'hC9: dec.kind = K_RET;
            8'h3A: dec.kind = K_LDA;
            8'h32: dec.kind = K_STA;
            default: undef = 1'b1;
        endcase
        dec.last_t = undef ? 4'd4 : kind_len(dec.kind);
    end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  aluop_e        op,
    output logic [DW-1:0] y
);
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOT:  y = ~a;
            OP_ROL:  y = {a[DW-2:0], a[DW-1]};
            default: y = {1'b0, a[DW-1:1]};
        endcase
    end
endmodule

// File: rtl/acc_cpu_tstate.sv
module acc_cpu_tstate
    import acc_cpu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          done,
    output logic [TW-1:0] t
);
    always_ff @(posedge clk) begin
        if (rst)
            t <= 4'd1;
        else if (!hold)
            t <= done ? 4'd1 : t + 4'd1;
    end
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic [DW-1:0] mem_rdata,
    output logic          halted
);
    localparam logic [AW-1:0] SLOT_LO = '1;
    localparam logic [AW-1:0] SLOT_HI = SLOT_LO - AW'(1);
    localparam logic [AW-1:0] PC_ONE  = AW'(1);
    localparam logic [AW-1:0] PC_TWO  = AW'(2);
    localparam logic [DW-1:0] D_ONE   = DW'(1);

    logic [AW-1:0] pc_q;
    logic [7:0]    ir_q;
    logic [DW-1:0] tmp_q, lo_q, hi_q;
    logic [DW-1:0] rf_q [0:3];
    logic          zf_q, sf_q, halted_q;
    logic [TW-1:0] t_q;
    dec_t          dec;
    logic [DW-1:0] alu_y, step_y;
    logic          taken, done, exec;

    acc_cpu_decode u_dec (.opc(ir_q), .dec(dec));

    acc_cpu_alu #(.DW(DW)) u_alu (
        .a(rf_q[R_A]), .b(tmp_q), .op(dec.op), .y(alu_y)
    );

    acc_cpu_tstate u_tst (
        .clk(clk), .rst(rst), .hold(halted_q), .done(done), .t(t_q)
    );

    always_comb begin
        case (dec.cc)
            CC_Z:    taken = zf_q;
            CC_NZ:   taken = !zf_q;
            CC_M:    taken = sf_q;
            default: taken = 1'b0;
        endcase
    end

    assign exec   = (t_q >= 4'd3);
    assign done   = (t_q == dec.last_t) ||
                    (dec.kind == K_JCC && t_q == 4'd4 && !taken);
    assign step_y = (dec.kind == K_DCR) ? rf_q[dec.dst] - D_ONE
                                        : rf_q[dec.dst] + D_ONE;
    assign halted = halted_q;

    // address and write strobe for the current T-state
    always_comb begin
        mem_addr  = pc_q;
        mem_we    = 1'b0;
        mem_wdata = rf_q[R_A];
        if (!halted_q && exec) begin
            case (dec.kind)
                K_RET: begin
                    if (t_q == 4'd3) mem_addr = SLOT_HI;
                    if (t_q == 4'd4) mem_addr = SLOT_LO;
                end
                K_CALL: begin
                    if (t_q == 4'd7) begin
                        mem_addr = SLOT_HI; mem_we = 1'b1; mem_wdata = pc_q[AW-1:DW];
                    end
                    if (t_q == 4'd8) begin
                        mem_addr = SLOT_LO; mem_we = 1'b1; mem_wdata = pc_q[DW-1:0];
                    end
                end
                K_LDA: if (t_q == 4'd9) mem_addr = {hi_q, lo_q};
                K_STA: if (t_q == 4'd9) begin
                    mem_addr = {hi_q, lo_q}; mem_we = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            ir_q     <= '0;
            tmp_q    <= '0;
            lo_q     <= '0;
            hi_q     <= '0;
            zf_q     <= 1'b0;
            sf_q     <= 1'b0;
            halted_q <= 1'b0;
            for (int i = 0; i < 4; i++) rf_q[i] <= '0;
        end else if (!halted_q) begin
            if (t_q == 4'd2) begin
                ir_q <= mem_rdata;
                pc_q <= pc_q + PC_ONE;
            end else if (exec) begin
                case (dec.kind)
                    K_MOV: if (t_q == 4'd4) rf_q[dec.dst] <= rf_q[dec.src];
                    K_INR, K_DCR: if (t_q == 4'd4) begin
                        rf_q[dec.dst] <= step_y;
                        zf_q <= (step_y == '0);
                        sf_q <= step_y[DW-1];
                    end
                    K_UNA: if (t_q == 4'd4) rf_q[R_A] <= alu_y;
                    K_HLT: if (t_q == 4'd4) halted_q <= 1'b1;
                    K_ALUR: begin
                        if (t_q == 4'd4) tmp_q <= rf_q[dec.src];
                        if (t_q == 4'd5) begin
                            rf_q[R_A] <= alu_y;
                            zf_q <= (alu_y == '0);
                            sf_q <= alu_y[DW-1];
                        end
                    end
                    K_MVI, K_ALUI: begin
                        if (t_q == 4'd4) begin
                            tmp_q <= mem_rdata;
                            pc_q  <= pc_q + PC_ONE;
                        end
                        if (dec.kind == K_MVI && t_q == 4'd6) rf_q[dec.dst] <= tmp_q;
                        if (dec.kind == K_ALUI && t_q == 4'd7) begin
                            rf_q[R_A] <= alu_y;
                            zf_q <= (alu_y == '0);
                            sf_q <= alu_y[DW-1];
                        end
                    end
                    K_JMP, K_JCC, K_CALL, K_LDA, K_STA: begin
                        if (t_q == 4'd4) begin
                            if (dec.kind == K_JCC && !taken) begin
                                pc_q <= pc_q + PC_TWO;
                            end else begin
                                lo_q <= mem_rdata;
                                pc_q <= pc_q + PC_ONE;
                            end
                        end
                        if (t_q == 4'd6) begin
                            hi_q <= mem_rdata;
                            pc_q <= pc_q + PC_ONE;
                        end
                        if ((dec.kind == K_JMP || dec.kind == K_JCC) && t_q == 4'd8)
                            pc_q <= {hi_q, lo_q};
                        if (dec.kind == K_CALL && t_q == 4'd9) pc_q <= {hi_q, lo_q};
                        if (dec.kind == K_LDA && t_q == 4'd10) rf_q[R_A] <= mem_rdata;
                    end
                    K_RET: begin
                        if (t_q == 4'd4) hi_q <= mem_rdata;
                        if (t_q == 4'd5) pc_q <= {hi_q, mem_rdata};
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/acc_cpu_core_chk.sv
module acc_cpu_core_chk
    import acc_cpu_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2 * DW
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic [DW-1:0] mem_rdata,
    input logic          halted,
    input logic [TW-1:0] t_q,
    input logic [7:0]    ir_q,
    input logic          zf_q,
    input logic          sf_q
);
    localparam logic [AW-1:0] TOP = '1;

    logic skip_jcc, go_jcc;
    assign skip_jcc = (ir_q == OPC_JZ && !zf_q) || (ir_q == OPC_JNZ && zf_q) ||
                      (ir_q == OPC_JM && !sf_q);
    assign go_jcc   = (ir_q == OPC_JZ && zf_q) || (ir_q == OPC_JNZ && !zf_q) ||
                      (ir_q == OPC_JM && sf_q);

    p_tstate_range_r8: assert property (@(posedge clk) disable iff (rst)
        t_q >= 4'd1 && t_q <= 4'd10);

    p_tstate_step_r8: assert property (@(posedge clk) disable iff (rst)
        !halted |=> (t_q == 4'd1 || t_q == $past(t_q) + 4'd1));

    p_fetch_no_write_r2: assert property (@(posedge clk) disable iff (rst)
        t_q <= 4'd3 |-> !mem_we);

    p_opcode_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (t_q == 4'd2 && !halted) |=> ir_q == $past(mem_rdata));

    p_jcc_short_r7: assert property (@(posedge clk) disable iff (rst)
        (t_q == 4'd4 && !halted && skip_jcc) |=> t_q == 4'd1);

    p_jcc_long_r7: assert property (@(posedge clk) disable iff (rst)
        (t_q == 4'd4 && !halted && go_jcc) |=> t_q == 4'd5);

    p_call_pair_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_addr == TOP - AW'(1)) |=> (mem_we && mem_addr == TOP));

    p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(mem_addr)));

    p_halt_no_write_r11: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we);
endmodule

bind acc_cpu_core acc_cpu_core_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .halted(halted), .t_q(t_q), .ir_q(ir_q),
    .zf_q(zf_q), .sf_q(sf_q)
);

// File: tb/acc_cpu_core_bench.sv
`timescale 1ns/1ps
module acc_cpu_core_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata;
    logic        halted;

    logic [7:0]  mem [0:1023];
    logic [23:0] exp_q [$];
    string       tag_q [$];
    int          n_chk = 0;
    int          n_fail = 0;
    int          ptr = 0;

    always #2 clk = ~clk;

    acc_cpu_core u_acc_cpu_core (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted)
    );

    // registered single-port memory, one cycle of read latency
    always @(posedge clk) begin
        if (mem_we === 1'b1) mem[mem_addr[9:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[9:0]];
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: every write is compared in order
    always @(negedge clk) begin
        if (!rst && mem_we === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected write", {8'h0, mem_addr, mem_wdata}, 32'h0);
            end else begin
                logic [23:0] e;
                string       s;
                e = exp_q.pop_front();
                s = tag_q.pop_front();
                chk({mem_addr, mem_wdata} == e, s, {8'h0, mem_addr, mem_wdata}, {8'h0, e});
            end
        end
    end

    task automatic org(input int a); ptr = a; endtask
    task automatic emit(input logic [7:0] b); mem[ptr] = b; ptr++; endtask
    task automatic sta(input logic [7:0] lo);
        emit(8'h32); emit(lo); emit(8'h02);
    endtask
    task automatic push_exp(input logic [15:0] a, input logic [7:0] d, input string t);
        exp_q.push_back({a, d});
        tag_q.push_back(t);
    endtask
    task automatic clear_mem;
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    endtask

    task automatic run_prog(input string tag, input int exp_cyc);
        int          n;
        bit          frozen;
        logic [15:0] a0;
        repeat (3) @(negedge clk);
        chk(mem_addr == 16'h0 && mem_we == 1'b0 && halted == 1'b0, "R1 reset state",
            {15'h0, mem_addr, mem_we, halted}, 32'h0);
        rst = 1'b0;
        n = 0;
        while (!halted && n < 4000) begin
            @(posedge clk); #1; n++;
        end
        chk(n == exp_cyc, {tag, " T-state total R8"}, n, exp_cyc);
        a0 = mem_addr;
        frozen = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!(halted && !mem_we && mem_addr == a0)) frozen = 1'b0;
        end
        chk(frozen, "R11 halt freeze", {15'h0, mem_addr, mem_we, halted}, {15'h0, a0, 1'b0, 1'b1});
        chk(exp_q.size() == 0, {tag, " pending writes R10"}, exp_q.size(), 0);
        @(negedge clk);
        rst = 1'b1;
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // multiply by repeated addition, R12
        clear_mem();
        org(0);
        emit(8'h3E); emit(8'h00); emit(8'h06); emit(8'h0C); emit(8'h0E); emit(8'h08);
        emit(8'h80); emit(8'h0D);
        emit(8'hCA); emit(8'h0E); emit(8'h00);
        emit(8'hC3); emit(8'h06); emit(8'h00);
        sta(8'h00); emit(8'h76);
        push_exp(16'h0200, 8'h60, "R12 product");
        run_prog("R12", 3*6 + 8*(5+4) + 7*(4+8) + 8 + 9 + 4);

        // ALU, register moves, wrap, undefined opcode, LDA
        clear_mem();
        org(0);
        emit(8'h3E); emit(8'h5A); emit(8'h06); emit(8'h0F); emit(8'h0E); emit(8'h30);
        emit(8'hA0); sta(8'h00); push_exp(16'h0200, 8'h0A, "R3 ANA B");
        emit(8'hB1); sta(8'h01); push_exp(16'h0201, 8'h3A, "R3 ORA C");
        emit(8'hA8); sta(8'h02); push_exp(16'h0202, 8'h35, "R3 XRA B");
        emit(8'h81); sta(8'h03); push_exp(16'h0203, 8'h65, "R3 ADD C");
        emit(8'h90); sta(8'h04); push_exp(16'h0204, 8'h56, "R3 SUB B");
        emit(8'hE6); emit(8'hF0); sta(8'h05); push_exp(16'h0205, 8'h50, "R3 ANI");
        emit(8'hF6); emit(8'h81); sta(8'h06); push_exp(16'h0206, 8'hD1, "R3 ORI");
        emit(8'hEE); emit(8'hFF); sta(8'h07); push_exp(16'h0207, 8'h2E, "R3 XRI");
        emit(8'h2F); sta(8'h08); push_exp(16'h0208, 8'hD1, "R4 CMA");
        emit(8'h17); sta(8'h09); push_exp(16'h0209, 8'hA3, "R4 RAL");
        emit(8'h1F); sta(8'h0A); push_exp(16'h020A, 8'h51, "R4 RAR");
        emit(8'h47); emit(8'h3E); emit(8'h00); emit(8'h78); sta(8'h0B);
        push_exp(16'h020B, 8'h51, "R5 MOV via B");
        emit(8'h4F); emit(8'h3E); emit(8'h00); emit(8'h79); sta(8'h0C);
        push_exp(16'h020C, 8'h51, "R5 MOV via C");
        emit(8'h3E); emit(8'hFF); emit(8'h3C); sta(8'h0D); push_exp(16'h020D, 8'h00, "R5 INR wrap");
        emit(8'h3D); sta(8'h0E); push_exp(16'h020E, 8'hFF, "R5 DCR wrap");
        emit(8'h00); emit(8'h08);
        emit(8'h3A); emit(8'h03); emit(8'h02); sta(8'h0F); push_exp(16'h020F, 8'h65, "R10 LDA");
        emit(8'h76);
        run_prog("R3 R11", 283);

        // flags, conditional jumps, call and return
        clear_mem();
        org(16'h00);
        emit(8'h06); emit(8'hFF); emit(8'h04); emit(8'h3E); emit(8'h11);
        emit(8'hC2); emit(8'h40); emit(8'h00);
        emit(8'hCA); emit(8'h10); emit(8'h00);
        sta(8'h10); emit(8'h76);
        org(16'h10);
        sta(8'h11); push_exp(16'h0211, 8'h11, "R7 JZ taken, JNZ skipped");
        emit(8'h05); emit(8'hFA); emit(8'h20); emit(8'h00);
        sta(8'h10); emit(8'h76);
        org(16'h20);
        emit(8'h0E); emit(8'h01); emit(8'h0D);
        emit(8'hFA); emit(8'h40); emit(8'h00);
        sta(8'h12); push_exp(16'h0212, 8'h11, "R6 DCR set flags, JM skipped");
        emit(8'hF6); emit(8'h80);
        emit(8'hCA); emit(8'h40); emit(8'h00);
        emit(8'hFA); emit(8'h33); emit(8'h00);
        emit(8'h76); emit(8'h76);
        sta(8'h13); push_exp(16'h0213, 8'h91, "R6 ORI set S, JM taken");
        emit(8'hCD); emit(8'h50); emit(8'h00);
        push_exp(16'hFFFE, 8'h00, "R9 return high byte");
        push_exp(16'hFFFF, 8'h39, "R9 return low byte");
        sta(8'h14); push_exp(16'h0214, 8'h92, "R9 RET resumes");
        emit(8'h76);
        org(16'h40);
        sta(8'h10); emit(8'h76);
        org(16'h50);
        emit(8'h3C); emit(8'hC9);
        run_prog("R7 R9", 131);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule